// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces one data-memory address for each advance request, taken from a single address register. An addressing mode is selected for each request. In linear mode the register moves by a signed step. In circular mode the register stays inside a buffer that is described by its base, its length and the step. In bit-reverse mode the register walks the reordered index sequence of a radix-2 FFT. Address checks and wrap-around are therefore handled in hardware, and an inner loop spends no instructions on them.

Four load strobes write the address, step, base and length registers. A load takes effect on the following cycle. When a load and an advance arrive in the same cycle, the advance works on the newly loaded value. The pre/post select decides which address is issued. With post-modify the register is issued before it is updated. With pre-modify the updated value is issued. The address leaves the unit registered, together with a one-cycle valid flag. The output carries no ready signal, so it applies no back-pressure. A consumer that cannot take an address every cycle must hold `adv` low instead. One unit serves one address stream. Dual-operand fetch uses two instances.

Top module: `dsp_agu`

## Requirements
- R1: After reset the address, step, base and length registers are zero, `addr_out` is zero and `addr_vld` is low.
- R2: Linear mode (`mode`=0) with post-modify (`pre_mod`=0): an advance issues the current register value, and the register then becomes register plus step.
- R3: Pre-modify (`pre_mod`=1): an advance issues the updated value, and the register also holds that value afterwards.
- R4: The step is a two's complement value. In linear mode the sum wraps modulo 2^AW, so a negative step counts downward through zero.
- R5: Circular mode (`mode`=1), forward: with offset = register − base, when offset + step ≥ length the new register is base + offset + step − length.
- R6: Circular mode, backward: when offset + step < 0 the new register is base + offset + step + length. The wrap is correct for step magnitudes up to the length.
- R7: Bit-reverse mode (`mode`=2): the length holds the FFT size N (a power of two). The step is added inside the low log2(N) bits, with the carry moving from the most significant of those bits toward bit 0. The bits above the field are kept. With N=8 and step 4, the register walks offsets 0,4,2,6,1,5,3,7 and then returns to 0.
- R8: When a load and an advance occur in the same cycle, the advance uses the loaded value, for the address as well as for the step.
- R9: `addr_vld` is high in exactly the cycle after each advance. `addr_out` holds its value when no advance occurs.
- R10: A load without an advance leaves `addr_out` and `addr_vld` unchanged. The loaded value is the one the next advance uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_addr | input | 1 | Load strobe for the address register |
| addr_in | input | AW | New address value |
| ld_step | input | 1 | Load strobe for the step register |
| step_in | input | AW | New signed step |
| ld_base | input | 1 | Load strobe for the buffer base |
| base_in | input | AW | New buffer base |
| ld_len | input | 1 | Load strobe for the length / FFT size |
| len_in | input | AW | New buffer length or FFT size |
| mode | input | 2 | 0 linear, 1 circular, 2 bit-reverse, 3 treated as linear |
| pre_mod | input | 1 | 1 issues the updated address, 0 issues the current one |
| adv | input | 1 | Advance request: issue one address and update the register |
| addr_out | output | AW | Issued address (registered) |
| addr_vld | output | 1 | High for one cycle after each advance |

## Verification
The bench builds the unit with AW=8. At that width the modulo-256 wrap of a negative linear step can be reached from a small starting address. A circular buffer of length 5 at base 0x40 exercises forward wraps, backward wraps, and a step equal to the length. An 8-point bit-reverse walk at base 0x30 shows that the carry stays inside the three-bit field and that the upper bits survive a full cycle of the sequence.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LIN  = 2'd0,
    AGU_CIRC = 2'd1,
    AGU_BREV = 2'd2,
    AGU_RSVD = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_modulo.sv
// Circular update: keeps the register inside [base, base+len-1].
module agu_modulo #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic [AW-1:0]        off;
  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] len_x;
  logic signed [EW-1:0] fixed;

  always_comb begin
    off   = cur - base;
    len_x = signed'({2'b00, len});
    sum   = signed'({2'b00, off}) + signed'({{2{step[AW-1]}}, step});
    if (sum < 0)
      fixed = sum + len_x;
    else if (sum >= len_x)
      fixed = sum - len_x;
    else
      fixed = sum;
    nxt = base + fixed[AW-1:0];
  end
endmodule

// File: rtl/agu_revcarry.sv
// Bit-reverse update: the step is added inside the field selected by len-1,
// with the carry moving from the field's top bit toward bit 0.
module agu_revcarry #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] mask;
  logic [AW-1:0] rc, rs, rsum, back;

  always_comb begin
    mask = len - 1'b1;
    for (int i = 0; i < AW; i++) begin
      rc[AW-1-i] = cur[i] & mask[i];
      rs[AW-1-i] = step[i] & mask[i];
    end
    // Field bit 0 sits at the top after reversal, so the carry leaves the word there.
    rsum = rc + rs;
    for (int i = 0; i < AW; i++)
      back[i] = rsum[AW-1-i];
    nxt = (cur & ~mask) | (back & mask);
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic [AW-1:0] addr_in,
  input  logic          ld_step,
  input  logic [AW-1:0] step_in,
  input  logic          ld_base,
  input  logic [AW-1:0] base_in,
  input  logic          ld_len,
  input  logic [AW-1:0] len_in,
  input  logic [1:0]    mode,
  input  logic          pre_mod,
  input  logic          adv,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  logic [AW-1:0] ar_q, step_q, base_q, len_q;
  logic [AW-1:0] a_eff, s_eff, b_eff, l_eff;
  logic [AW-1:0] lin_nxt, circ_nxt, brev_nxt, nxt;
  agu_mode_e     mode_e;

  // Same-cycle loads are forwarded so an advance sees the new values.
  assign a_eff = ld_addr ? addr_in : ar_q;
  assign s_eff = ld_step ? step_in : step_q;
  assign b_eff = ld_base ? base_in : base_q;
  assign l_eff = ld_len  ? len_in  : len_q;

  assign lin_nxt = a_eff + s_eff;

  agu_modulo #(.AW(AW)) u_modulo (
    .cur(a_eff), .step(s_eff), .base(b_eff), .len(l_eff), .nxt(circ_nxt)
  );

  agu_revcarry #(.AW(AW)) u_revcarry (
    .cur(a_eff), .step(s_eff), .len(l_eff), .nxt(brev_nxt)
  );

  always_comb begin
    mode_e = agu_mode_e'(mode);
    unique case (mode_e)
      AGU_CIRC: nxt = circ_nxt;
      AGU_BREV: nxt = brev_nxt;
      default:  nxt = lin_nxt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q     <= '0;
      step_q   <= '0;
      base_q   <= '0;
      len_q    <= '0;
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      step_q   <= s_eff;
      base_q   <= b_eff;
      len_q    <= l_eff;
      ar_q     <= adv ? nxt : a_eff;
      addr_vld <= adv;
      if (adv)
        addr_out <= pre_mod ? nxt : a_eff;
    end
  end
endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv,
  input logic          pre_mod,
  input logic          ld_addr,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          addr_vld,
  input logic [AW-1:0] ar_q
);
  p_vld_after_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> addr_vld);
  p_vld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !addr_vld);
  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(addr_out));
  p_post_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pre_mod && !ld_addr) |=> addr_out == $past(ar_q));
  p_pre_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pre_mod) |=> addr_out == ar_q);
  p_load_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pre_mod && ld_addr) |=> addr_out == $past(addr_in));
endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .pre_mod(pre_mod), .ld_addr(ld_addr),
  .addr_in(addr_in), .addr_out(addr_out), .addr_vld(addr_vld), .ar_q(ar_q)
);

// File: tb/dsp_agu_tb.sv
module dsp_agu_tb;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic ld_addr = 0, ld_step = 0, ld_base = 0, ld_len = 0;
  logic [AW-1:0] addr_in = '0, step_in = '0, base_in = '0, len_in = '0;
  logic [1:0] mode = 0;
  logic pre_mod = 0, adv = 0;
  logic [AW-1:0] addr_out;
  logic addr_vld;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dsp_agu #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .addr_in(addr_in),
    .ld_step(ld_step), .step_in(step_in), .ld_base(ld_base), .base_in(base_in),
    .ld_len(ld_len), .len_in(len_in), .mode(mode), .pre_mod(pre_mod),
    .adv(adv), .addr_out(addr_out), .addr_vld(addr_vld)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Load all four registers, no advance.
  task automatic load_all(input int a, input int s, input int b, input int l);
    @(negedge clk);
    ld_addr = 1; ld_step = 1; ld_base = 1; ld_len = 1;
    addr_in = a[AW-1:0]; step_in = s[AW-1:0]; base_in = b[AW-1:0]; len_in = l[AW-1:0];
    @(negedge clk);
    ld_addr = 0; ld_step = 0; ld_base = 0; ld_len = 0;
  endtask

  // One advance; returns the issued address and checks the valid pulse.
  task automatic go(input int md, input bit pre, output int got);
    @(negedge clk);
    mode = md[1:0]; pre_mod = pre; adv = 1;
    @(negedge clk);
    adv = 0;
    got = int'(addr_out);
    chk("R9 vld", int'(addr_vld), 1);
  endtask

  task automatic t_reset;
    chk("R1 addr_out", int'(addr_out), 0);
    chk("R1 addr_vld", int'(addr_vld), 0);
  endtask

  task automatic t_linear_post;
    int g;
    load_all(8'h10, 3, 0, 0);
    go(0, 0, g); chk("R2 first", g, 8'h10);
    go(0, 0, g); chk("R2 second", g, 8'h13);
    @(negedge clk);
    chk("R9 vld drops", int'(addr_vld), 0);
    chk("R9 hold", int'(addr_out), 8'h13);
  endtask

  task automatic t_pre;
    int g;
    load_all(10, 3, 0, 0);
    go(0, 1, g); chk("R3 first", g, 13);
    go(0, 1, g); chk("R3 second", g, 16);
  endtask

  task automatic t_negative;
    int g;
    load_all(3, -5, 0, 0);
    go(0, 0, g); chk("R4 start", g, 3);
    go(0, 0, g); chk("R4 wrap", g, 8'hFE);
  endtask

  task automatic t_circ_fwd;
    int g;
    int exp[5] = '{8'h43, 8'h40, 8'h42, 8'h44, 8'h41};
    load_all(8'h43, 2, 8'h40, 5);
    for (int i = 0; i < 5; i++) begin
      go(1, 0, g); chk("R5 circ fwd", g, exp[i]);
    end
    load_all(8'h42, 5, 8'h40, 5);
    go(1, 0, g); go(1, 0, g); chk("R5 step=len", g, 8'h42);
  endtask

  task automatic t_circ_bwd;
    int g;
    int exp[4] = '{8'h41, 8'h43, 8'h40, 8'h42};
    load_all(8'h41, -3, 8'h40, 5);
    for (int i = 0; i < 4; i++) begin
      go(1, 0, g); chk("R6 circ bwd", g, exp[i]);
    end
  endtask

  task automatic t_bitrev;
    int g;
    int ord[9] = '{0, 4, 2, 6, 1, 5, 3, 7, 0};
    load_all(8'h30, 4, 0, 8);
    for (int i = 0; i < 9; i++) begin
      go(2, 0, g); chk("R7 bitrev", g, 8'h30 + ord[i]);
    end
  endtask

  task automatic t_same_cycle;
    int g;
    load_all(1, 1, 0, 0);
    @(negedge clk);
    ld_addr = 1; addr_in = 100; ld_step = 1; step_in = 7;
    mode = 0; pre_mod = 0; adv = 1;
    @(negedge clk);
    ld_addr = 0; ld_step = 0; adv = 0;
    chk("R8 new addr", int'(addr_out), 100);
    go(0, 0, g); chk("R8 new step", g, 107);
  endtask

  task automatic t_load_only;
    int g;
    load_all(20, 1, 0, 0);
    go(0, 0, g);
    @(negedge clk);
    ld_addr = 1; addr_in = 8'h77;
    @(negedge clk);
    ld_addr = 0;
    chk("R10 out held", int'(addr_out), 20);
    chk("R10 no vld", int'(addr_vld), 0);
    go(0, 0, g); chk("R10 next uses load", g, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_linear_post();
    t_pre();
    t_negative();
    t_circ_fwd();
    t_circ_bwd();
    t_bitrev();
    t_same_cycle();
    t_load_only();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule